// File: doc/BRIEF.md
# I2C Register-Access Slave Interface

This block is a synchronous I2C slave that gives an external bus master read and write access to a bank of 128 byte-wide registers. The raw clock and data lines are brought into the system clock domain through two-flop synchronisers. The block finds START, repeated START and STOP conditions on the synchronised lines and answers only to one fixed 7-bit device address. After the address, the master sends a sub-address byte that sets the register pointer. Later bytes then write to the register file or read from it, depending on the direction bit of the most recent address byte.

The top bit of the sub-address picks the access style. When it is clear, every data byte of the transaction targets the same register. When it is set, the pointer steps forward after each byte and wraps from the last register back to the first. The pad interface is open-drain. The block never drives a line high: `sda_oe` and `scl_oe` only pull their line low. After each acknowledge cycle the slave can hold the clock low for a fixed number of system clocks, which forces the master to wait.

Top module: `i2cs_regport`

## Requirements
- R1: After reset, `sda_oe` and `scl_oe` are 0 and every register reads back as 0x00.
- R2: An address byte is seven address bits followed by a direction bit (0 = write, 1 = read), most significant bit first. When the seven bits equal `DEV_ADDR` (default 0x69), the slave pulls SDA low for the ninth clock.
- R3: When the address does not match, the slave does not acknowledge. It drives nothing and changes no register for the rest of the traffic, until the next START or STOP. A matching address after a repeated START is served normally.
- R4: The sub-address byte is acknowledged. Its bits 6..0 load the register pointer, and its bit 7 sets burst mode (1) or single-register mode (0) for the transaction.
- R5: In a write, each data byte is received MSB first, acknowledged, and stored in the register at the pointer. A transaction may carry any number of bytes.
- R6: With bit 7 of the sub-address clear, every data byte of the transaction, written or read, uses the same register.
- R7: With bit 7 of the sub-address set, the pointer advances by one after each data byte and wraps from 127 to 0.
- R8: After a repeated START and a matching address with the read bit set, the slave returns the register at the pointer MSB first. A master ACK (SDA low on the ninth clock) asks for the next byte. After a master NACK, the slave leaves SDA released until the next START or STOP.
- R9: A repeated START restarts bit framing but keeps the pointer and burst mode. A read that follows a burst write therefore continues at the register after the last one written.
- R10: After each acknowledge cycle ends, the slave holds SCL low for `STRETCH_CYC` system clocks (default 40; 0 turns stretching off). The next clock high phase starts only after the line is released.
- R11: A STOP (SDA rising while SCL is high) always returns the slave to idle. A START (SDA falling while SCL is high) always begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed bus clock line level |
| sda_i | input | 1 | Sensed bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| scl_oe | output | 1 | 1 pulls the clock line low for stretching, 0 releases it |

## Verification
The bench aims at pointer corner cases. A burst that starts at register 126 has to wrap to 0; a design with a pointer that saturates, or one bit too wide, would write beyond the bank or leave register 127 overwritten. A single-register transaction must leave neighbouring registers untouched, which shows up a pointer that advances when it should not. A read after a repeated START must continue where a burst write stopped, which catches a design that clears the pointer on any START. A wrong address followed by data, a read that goes on after the master's NACK, and a measurement of how long the clock is held low catch, in turn: a slave that acknowledges or writes for a foreign address, one that keeps driving data after a NACK, and one that never stretches the clock.

// File: rtl/i2cs_pkg.sv
// Package i2cs_pkg
// Shared types for the I2C register-access slave: the protocol state encoding
// and the fixed byte width of the bus. Assumes 8-bit bus bytes.
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } i2cs_state_e;

endpackage

// File: rtl/i2cs_line_sync.sv
// Module i2cs_line_sync
// Brings N asynchronous bus lines into the clock domain through two flops
// each. It gives the synchronised level and one-cycle rise and fall pulses.
// Assumes the lines idle high, so every stage resets to 1.
module i2cs_line_sync #(
    parameter int N_LINES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw_i,
    output logic [N_LINES-1:0] lvl_o,
    output logic [N_LINES-1:0] rise_o,
    output logic [N_LINES-1:0] fall_o
);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic s1, s2, s3;

        // two-flop synchroniser plus one history flop for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
                s3 <= 1'b1;
            end else begin
                s1 <= raw_i[g];
                s2 <= s1;
                s3 <= s2;
            end
        end

        assign lvl_o[g]  = s2;
        assign rise_o[g] = s2 & ~s3;
        assign fall_o[g] = ~s2 & s3;
    end

endmodule

// File: rtl/i2cs_reg_bank.sv
// Module i2cs_reg_bank
// Byte-wide register file with one synchronous write port and one
// combinational read port. Assumes the depth is a power of two, so the
// address width covers it exactly. All registers reset to zero.
module i2cs_reg_bank #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    // storage update: clear on reset, otherwise one write per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // read port
    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/i2cs_stretch.sv
// Module i2cs_stretch
// Holds the bus clock low for a fixed number of system cycles after each
// trigger pulse. The parameter picks the variant: 0 gives a block that never
// pulls SCL. Assumes trigger pulses are much further apart than the hold.
module i2cs_stretch #(
    parameter int HOLD_CYC = 40,
    localparam int CW      = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic scl_oe_o
);

    if (HOLD_CYC > 0) begin : g_on
        logic [CW-1:0] cnt;

        // countdown started by each trigger, clock held while it is non-zero
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (trig_i)     cnt <= CW'(HOLD_CYC);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
        end

        assign scl_oe_o = (cnt != '0);

        // R10: a trigger leads to SCL being held in the next cycle
        p_hold_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
            trig_i |=> scl_oe_o);
        // R10: the hold only begins on a trigger
        p_hold_needs_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(scl_oe_o) |-> $past(trig_i));
    end else begin : g_off
        assign scl_oe_o = 1'b0;
    end

endmodule

// File: rtl/i2cs_ctrl.sv
// Module i2cs_ctrl
// Protocol engine of the I2C slave. Works only on synchronised line levels
// and edges. It frames bytes, checks the device address, keeps the register
// pointer and burst flag, and drives SDA by output enable only. Assumes SDA
// changes only while SCL is low, apart from START and STOP.
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         AW       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_lvl_i,
    input  logic              sda_rise_i,
    input  logic              sda_fall_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [AW-1:0]     ptr_o,
    output logic              we_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              sda_oe_o,
    output logic              ack_end_o
);

    i2cs_state_e       state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [AW-1:0]     ptr;
    logic              burst;
    logic              is_read;
    logic              mack;
    logic              start_evt, stop_evt, byte_done;

    // bus conditions: data edges while the clock is high
    assign start_evt = sda_fall_i & scl_lvl_i;
    assign stop_evt  = sda_rise_i & scl_lvl_i;
    assign byte_done = scl_fall_i && (bitcnt == CNT_W'(BYTE_W));

    // register write strobe at the end of a received data byte
    assign we_o    = (state == ST_WR) && byte_done && !start_evt && !stop_evt;
    assign wdata_o = shreg;
    assign ptr_o   = ptr;

    // protocol state machine, bit framing, pointer and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            burst     <= 1'b0;
            is_read   <= 1'b0;
            mack      <= 1'b0;
            sda_oe_o  <= 1'b0;
            ack_end_o <= 1'b0;
        end else begin
            ack_end_o <= 1'b0;
            if (stop_evt) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else if (start_evt) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_SUB, ST_WR: begin
                        if (scl_rise_i) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_lvl_i};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                    state    <= ST_ADDR_ACK;
                                    is_read  <= shreg[0];
                                    sda_oe_o <= 1'b1;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_SUB) begin
                                ptr      <= shreg[AW-1:0];
                                burst    <= shreg[BYTE_W-1];
                                state    <= ST_SUB_ACK;
                                sda_oe_o <= 1'b1;
                            end else begin
                                if (burst) ptr <= ptr + 1'b1;
                                state    <= ST_WR_ACK;
                                sda_oe_o <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall_i) begin
                            ack_end_o <= 1'b1;
                            bitcnt    <= '0;
                            if (is_read) begin
                                state    <= ST_RD;
                                shreg    <= rdata_i;
                                sda_oe_o <= ~rdata_i[BYTE_W-1];
                            end else begin
                                state    <= ST_SUB;
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    ST_SUB_ACK, ST_WR_ACK: begin
                        if (scl_fall_i) begin
                            ack_end_o <= 1'b1;
                            state     <= ST_WR;
                            sda_oe_o  <= 1'b0;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise_i) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            bitcnt   <= '0;
                            state    <= ST_RD_ACK;
                            sda_oe_o <= 1'b0;
                            if (burst) ptr <= ptr + 1'b1;
                        end else if (scl_fall_i) begin
                            shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe_o <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise_i) begin
                            mack <= ~sda_lvl_i;
                        end else if (scl_fall_i) begin
                            if (mack) begin
                                ack_end_o <= 1'b1;
                                state     <= ST_RD;
                                shreg     <= rdata_i;
                                sda_oe_o  <= ~rdata_i[BYTE_W-1];
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: the slave starts pulling SDA only in an ack slot or while sending data
    p_drive_where_allowed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> (state inside {ST_ADDR_ACK, ST_SUB_ACK, ST_WR_ACK, ST_RD}));
    // R3: a slave that is ignoring traffic never drives SDA
    p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe_o);
    // R11: a STOP returns the engine to idle
    p_stop_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE));
    // R9: a START reframes but keeps the register pointer
    p_start_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ADDR) && (ptr == $past(ptr)));
    // R7: a burst write at the top register wraps the pointer to zero
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && burst && (ptr == {AW{1'b1}})) |=> (ptr == '0));
    // R6: in single-register mode a data byte leaves the pointer in place
    p_no_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && !burst) |=> $stable(ptr));
    // R5: SDA drive changes only while the synchronised clock is low
    p_sda_when_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_lvl_i);

endmodule

// File: rtl/i2cs_regport.sv
// Module i2cs_regport
// Top level of the I2C register-access slave. It wires the line
// synchroniser, the protocol engine, the register bank and the clock-stretch
// unit together. Assumes open-drain pads: each *_oe output pulls its line low.
module i2cs_regport #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         REG_DEPTH   = 128,
    parameter int         STRETCH_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic scl_oe
);

    import i2cs_pkg::*;

    localparam int AW = $clog2(REG_DEPTH);

    logic [1:0]        lvl, rise, fall;
    logic [AW-1:0]     ptr;
    logic              we, ack_end;
    logic [BYTE_W-1:0] wdata, rdata;

    i2cs_line_sync #(.N_LINES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    i2cs_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (lvl[0]),
        .scl_rise_i (rise[0]),
        .scl_fall_i (fall[0]),
        .sda_lvl_i  (lvl[1]),
        .sda_rise_i (rise[1]),
        .sda_fall_i (fall[1]),
        .rdata_i    (rdata),
        .ptr_o      (ptr),
        .we_o       (we),
        .wdata_o    (wdata),
        .sda_oe_o   (sda_oe),
        .ack_end_o  (ack_end)
    );

    i2cs_reg_bank #(.DEPTH(REG_DEPTH), .DATA_W(BYTE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (ptr),
        .wdata_i (wdata),
        .raddr_i (ptr),
        .rdata_o (rdata)
    );

    i2cs_stretch #(.HOLD_CYC(STRETCH_CYC)) u_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (ack_end),
        .scl_oe_o (scl_oe)
    );

endmodule

// File: tb/i2cs_regport_tb_top.sv
// Bench for i2cs_regport: a bit-level I2C master model with wired-AND lines,
// a table of write/read transactions checked against a behavioural register
// model, then directed tests for reset, a foreign address, master NACK,
// pointer continuation across repeated START, and clock stretching.
module i2cs_regport_tb_top;

    localparam int HALF = 25;
    localparam logic [6:0] DEV = 7'h69;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe, scl_oe;
    logic scl_line, sda_line;

    always #2.5 clk = ~clk;

    assign scl_line = scl_drv & ~scl_oe;
    assign sda_line = sda_drv & ~sda_oe;

    i2cs_regport #(.DEV_ADDR(DEV), .REG_DEPTH(128), .STRETCH_CYC(40)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_line),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .scl_oe (scl_oe)
    );

    int tests = 0;
    int fails = 0;
    int max_wait = 0;
    bit done = 1'b0;

    logic [7:0] mem [128];
    logic [6:0] mptr = '0;
    logic       mburst = 1'b0;

    // {is_read, sub-address, byte count, data seed}
    localparam logic [24:0] VEC [9] = '{
        {1'b0, 8'h85, 8'd4, 8'h11},
        {1'b1, 8'h85, 8'd4, 8'h00},
        {1'b0, 8'h0A, 8'd3, 8'h40},
        {1'b1, 8'h89, 8'd3, 8'h00},
        {1'b0, 8'hFE, 8'd4, 8'h70},
        {1'b1, 8'hFE, 8'd4, 8'h00},
        {1'b1, 8'h0A, 8'd3, 8'h00},
        {1'b0, 8'h80, 8'd1, 8'hC3},
        {1'b1, 8'hFF, 8'd3, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_high();
        int w;
        w = 0;
        scl_drv = 1'b1;
        #1;
        while (!scl_line && w < 2000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 2000) check(1'b0, "R10 clock release", w, 0);
        if (w > max_wait) max_wait = w;
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; scl_drv = 1'b1; wait_n(HALF);
        sda_drv = 1'b0; wait_n(HALF);
        scl_drv = 1'b0; wait_n(HALF);
    endtask

    task automatic bus_rstart();
        sda_drv = 1'b1; wait_n(HALF);
        scl_high(); wait_n(HALF);
        sda_drv = 1'b0; wait_n(HALF);
        scl_drv = 1'b0; wait_n(HALF);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_n(HALF);
        scl_high(); wait_n(HALF);
        sda_drv = 1'b1; wait_n(2 * HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wait_n(HALF);
            scl_high(); wait_n(HALF);
            scl_drv = 1'b0;
        end
        sda_drv = 1'b1; wait_n(HALF);
        scl_high(); wait_n(HALF / 2);
        acked = (sda_line == 1'b0);
        wait_n(HALF - HALF / 2);
        scl_drv = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_n(HALF);
            scl_high(); wait_n(HALF / 2);
            b[i] = sda_line;
            wait_n(HALF - HALF / 2);
            scl_drv = 1'b0;
        end
        sda_drv = ~give_ack; wait_n(HALF);
        scl_high(); wait_n(HALF);
        scl_drv = 1'b0; wait_n(2);
        sda_drv = 1'b1;
    endtask

    task automatic m_set(input logic [7:0] sub);
        mptr = sub[6:0];
        mburst = sub[7];
    endtask

    task automatic m_wr(input logic [7:0] d);
        mem[mptr] = d;
        if (mburst) mptr = mptr + 1'b1;
    endtask

    task automatic m_rd(output logic [7:0] d);
        d = mem[mptr];
        if (mburst) mptr = mptr + 1'b1;
    endtask

    task automatic do_write(input logic [7:0] sub, input int cnt, input logic [7:0] seed);
        bit a;
        logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b0}, a); check(a, "R2 address ack (write)", a, 1);
        send_byte(sub, a);         check(a, "R4 sub-address ack", a, 1);
        m_set(sub);
        for (int i = 0; i < cnt; i++) begin
            d = seed + 8'(i * 8'h13);
            send_byte(d, a); check(a, "R5 data ack", a, 1);
            m_wr(d);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] sub, input int cnt);
        bit a;
        logic [7:0] got, exp;
        bus_start();
        send_byte({DEV, 1'b0}, a); check(a, "R2 address ack (write)", a, 1);
        send_byte(sub, a);         check(a, "R4 sub-address ack", a, 1);
        m_set(sub);
        bus_rstart();
        send_byte({DEV, 1'b1}, a); check(a, "R8 read address ack", a, 1);
        for (int i = 0; i < cnt; i++) begin
            recv_byte(i != cnt - 1, got);
            m_rd(exp);
            check(got == exp, "R8/R6/R7 read data", got, exp);
        end
        bus_stop();
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] got, exp;
        for (int i = 0; i < 128; i++) mem[i] = 8'h00;

        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        // R1: outputs released after reset
        check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        check(scl_oe == 1'b0, "R1 scl_oe after reset", scl_oe, 0);
        // R1: a register reads as zero after reset
        do_read(8'h33, 1);

        // table of transactions; R6 single-register, R7 burst with wrap
        max_wait = 0;
        for (int v = 0; v < 9; v++) begin
            if (VEC[v][24]) do_read(VEC[v][23:16], int'(VEC[v][15:8]));
            else            do_write(VEC[v][23:16], int'(VEC[v][15:8]), VEC[v][7:0]);
            if (v == 0) check(max_wait >= 10, "R10 clock held low after ack", max_wait, 10);
        end

        // R3: foreign address gets no ack and its data is ignored
        bus_start();
        send_byte({7'h3A, 1'b0}, a); check(!a, "R3 foreign address nack", a, 0);
        send_byte(8'h05, a);         check(!a, "R3 ignored sub-address", a, 0);
        send_byte(8'h99, a);         check(!a, "R3 ignored data", a, 0);
        // R3: a repeated START with a matching address is served
        bus_rstart();
        send_byte({DEV, 1'b0}, a);   check(a, "R3 match after repeated START", a, 1);
        send_byte(8'h20, a);         check(a, "R4 sub-address ack", a, 1);
        m_set(8'h20);
        send_byte(8'h5A, a);         check(a, "R5 data ack", a, 1);
        m_wr(8'h5A);
        bus_stop();
        do_read(8'h05, 1);
        do_read(8'h20, 1);

        // R9: burst write, then repeated START read continues from the pointer
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h90, a); m_set(8'h90);
        send_byte(8'hA1, a); m_wr(8'hA1);
        send_byte(8'hA2, a); m_wr(8'hA2);
        bus_rstart();
        send_byte({DEV, 1'b1}, a); check(a, "R9 read address ack", a, 1);
        recv_byte(1'b0, got);
        m_rd(exp);
        check(got == exp && exp == 8'h00, "R9 pointer kept across repeated START", got, exp);
        // R8: after a NACK the slave keeps SDA released
        recv_byte(1'b0, got);
        check(got == 8'hFF, "R8 silent after master NACK", got, 8'hFF);
        bus_stop();
        do_read(8'h90, 2);

        // R11: a STOP in the middle of a byte returns to idle, next access works
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h40, a);
        sda_drv = 1'b1; wait_n(HALF);
        scl_high(); wait_n(HALF); scl_drv = 1'b0;
        bus_stop();
        do_read(8'h40, 1);
        check(sda_oe == 1'b0, "R11 idle after STOP", sda_oe, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule